// File: doc/BRIEF.md
# Interleaved Dual-Channel Sample Demultiplexer

A dual-channel converter drives a single bit-parallel bus. Every lane always carries the same bit position. The two channels share that bus in time. Within each sample slot, the channel 0 word comes first and the channel 1 word follows. This block tracks which of the two beats is on the bus. It sends channel 0 words into one small FIFO and channel 1 words into another. A downstream consumer drains the two FIFOs on its own schedule.

The input is a word that has already been captured, plus a valid strobe. The block takes one word on every valid cycle and never stalls. Each FIFO reports full, empty and an occupancy count, and a read returns data one cycle after the read request.

The block writes the two words of a sample as a pair, so the two FIFOs stay aligned sample for sample. A word that arrives at a full FIFO is discarded and leaves a sticky flag behind. A resync input lets the source force the channel phase back to channel 0.

Top module: `adc_pair_demux`

## Requirements
- R1: After a synchronous reset both FIFOs are empty, both counts are 0, full is low and both overflow flags are low.
- R2: After reset, valid beats alternate channel 0, channel 1, channel 0, and so on. Cycles with in_valid low do not move the phase.
- R3: Each stored entry is the whole in_word of one beat, with lane n as bit n (bit 13 MSB). Channel 0 words appear only at rd0_data and channel 1 words only at rd1_data.
- R4: Each FIFO returns entries oldest first. rd_data takes the head entry on the first rising edge after rdN_en is sampled high. A read of an empty FIFO leaves its count and pointers unchanged.
- R5: countN equals the number of stored entries, from 0 to 8. fullN is high exactly at 8 and emptyN exactly at 0.
- R6: A valid beat on every consecutive cycle is accepted with no gap or stall.
- R7: A beat whose FIFO is full is dropped and sets that channel's overflow flag, which stays set until reset. The phase still advances.
- R8: A channel 1 word is stored only if the channel 0 word of the same sample was stored. Otherwise it is dropped, and ovf1 does not change unless FIFO 1 is also full.
- R9: When resync is high together with in_valid, that beat is channel 0. When resync is high without in_valid, the next valid beat is channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat strobe |
| in_word | input | 14 | Captured lane word, lane n = bit n |
| resync | input | 1 | Force channel 0 phase |
| rd0_en | input | 1 | Read request, channel 0 FIFO |
| rd0_data | output | 14 | Channel 0 read data |
| full0 | output | 1 | Channel 0 FIFO full |
| empty0 | output | 1 | Channel 0 FIFO empty |
| count0 | output | 4 | Channel 0 occupancy |
| ovf0 | output | 1 | Channel 0 sticky overflow |
| rd1_en | input | 1 | Read request, channel 1 FIFO |
| rd1_data | output | 14 | Channel 1 read data |
| full1 | output | 1 | Channel 1 FIFO full |
| empty1 | output | 1 | Channel 1 FIFO empty |
| count1 | output | 4 | Channel 1 occupancy |
| ovf1 | output | 1 | Channel 1 sticky overflow |

## Verification
The assertions assume that rst is held for at least one clock edge before any beat. They also assume that resync, in_valid and the read enables change only between clock edges. With those inputs the phase, the occupancy bound, the no-write-when-full behaviour and the sticky flags must all hold. The bench drives every input on the falling edge and begins with a reset. Fills are pushed past depth 8 on purpose, with the two FIFOs at different levels, so that full drops, pair drops and resync each occur under legal input timing.

// File: rtl/adc_pair_demux.sv
module adc_pair_demux #(
  parameter int W = 14,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  input  logic          resync,
  input  logic          rd0_en,
  output logic [W-1:0]  rd0_data,
  output logic          full0,
  output logic          empty0,
  output logic [CW-1:0] count0,
  output logic          ovf0,
  input  logic          rd1_en,
  output logic [W-1:0]  rd1_data,
  output logic          full1,
  output logic          empty1,
  output logic [CW-1:0] count1,
  output logic          ovf1
);

  logic          phase, pair_ok, cur;
  logic [1:0]    wr, rd, full, empty, ovf, rd_req;
  logic [CW-1:0] cnt  [2];
  logic [AW-1:0] wp   [2];
  logic [AW-1:0] rp   [2];
  logic [W-1:0]  rdat [2];
  logic [W-1:0]  mem  [2][DEPTH];

  assign cur    = resync ? 1'b0 : phase;
  assign rd_req = {rd1_en, rd0_en};
  assign wr[0]  = in_valid & ~cur & ~full[0];
  assign wr[1]  = in_valid &  cur & ~full[1] & pair_ok;
  assign rd     = rd_req & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      pair_ok <= 1'b0;
    end else if (in_valid) begin
      phase   <= ~cur;
      pair_ok <= ~cur & wr[0];
    end else if (resync) begin
      phase   <= 1'b0;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign full[c]  = (cnt[c] == CW'(DEPTH));
    assign empty[c] = (cnt[c] == '0);

    always_ff @(posedge clk) begin
      if (wr[c]) mem[c][wp[c]] <= in_word;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp[c]   <= '0;
        rp[c]   <= '0;
        cnt[c]  <= '0;
        ovf[c]  <= 1'b0;
        rdat[c] <= '0;
      end else begin
        if (wr[c]) wp[c] <= (wp[c] == AW'(DEPTH - 1)) ? '0 : wp[c] + 1'b1;
        if (rd[c]) begin
          rdat[c] <= mem[c][rp[c]];
          rp[c]   <= (rp[c] == AW'(DEPTH - 1)) ? '0 : rp[c] + 1'b1;
        end
        cnt[c] <= cnt[c] + CW'(wr[c]) - CW'(rd[c]);
        if (in_valid && (cur == 1'(c)) && full[c]) ovf[c] <= 1'b1;
      end
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
      cnt[c] <= CW'(DEPTH));
    p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
      full[c] && !rd_req[c] |=> full[c]);
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      ovf[c] |=> ovf[c]);
    p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
      empty[c] && !wr[c] |=> empty[c]);
  end

  p_phase_alt_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !resync && !phase |=> phase);
  p_resync_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && resync |=> phase);

  assign rd0_data = rdat[0];
  assign rd1_data = rdat[1];
  assign full0    = full[0];
  assign full1    = full[1];
  assign empty0   = empty[0];
  assign empty1   = empty[1];
  assign count0   = cnt[0];
  assign count1   = cnt[1];
  assign ovf0     = ovf[0];
  assign ovf1     = ovf[1];

endmodule

// File: tb/sim_adc_pair_demux.sv
module sim_adc_pair_demux;
  logic clk = 1'b0, rst = 1'b0, in_valid = 1'b0, resync = 1'b0;
  logic [13:0] in_word = '0;
  logic rd0_en = 1'b0, rd1_en = 1'b0;
  logic [13:0] rd0_data, rd1_data;
  logic full0, full1, empty0, empty1, ovf0, ovf1;
  logic [3:0] count0, count1;

  adc_pair_demux u0 (.clk, .rst, .in_valid, .in_word, .resync,
    .rd0_en, .rd0_data, .full0, .empty0, .count0, .ovf0,
    .rd1_en, .rd1_data, .full1, .empty1, .count1, .ovf1);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [13:0] q0[$], q1[$];
  int mcnt [2];
  bit movf [2];
  bit mph, mpair;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; resync = 1'b0;
    @(negedge clk); rst = 1'b0;
    q0.delete(); q1.delete();
    mcnt[0] = 0; mcnt[1] = 0; movf[0] = 0; movf[1] = 0; mph = 0; mpair = 0;
  endtask

  // driver: one beat per call, consecutive calls give back-to-back beats
  task automatic beat(input logic [13:0] w, input bit rs);
    bit ch;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; resync = rs;
    ch = rs ? 1'b0 : mph;
    if (!ch) begin
      if (mcnt[0] < 8) begin q0.push_back(w); mcnt[0]++; mpair = 1; end
      else begin movf[0] = 1; mpair = 0; end
      mph = 1;
    end else begin
      if (mcnt[1] == 8) movf[1] = 1;
      else if (mpair) begin q1.push_back(w); mcnt[1]++; end
      mpair = 0;
      mph = 0;
    end
  endtask

  task automatic idle(input bit rs);
    @(negedge clk); in_valid = 1'b0; resync = rs;
    if (rs) mph = 0;
  endtask

  // monitor: issue a read and compare against the scoreboard head
  task automatic do_read(input int ch, input string tag);
    logic [13:0] exp, act;
    @(negedge clk);
    in_valid = 1'b0; resync = 1'b0;
    if (ch == 0) rd0_en = 1'b1; else rd1_en = 1'b1;
    @(negedge clk);
    rd0_en = 1'b0; rd1_en = 1'b0;
    act = (ch == 0) ? rd0_data : rd1_data;
    if (ch == 0 ? q0.size() == 0 : q1.size() == 0) begin
      check(0, {tag, " scoreboard empty"}, act, 0);
    end else begin
      exp = (ch == 0) ? q0.pop_front() : q1.pop_front();
      mcnt[ch]--;
      check(act == exp, tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(count0 == 4'(mcnt[0]), {tag, " count0"}, count0, mcnt[0]);
    check(count1 == 4'(mcnt[1]), {tag, " count1"}, count1, mcnt[1]);
    check(full0 == (mcnt[0] == 8) && empty0 == (mcnt[0] == 0), {tag, " flags0"}, {full0, empty0}, {mcnt[0] == 8, mcnt[0] == 0});
    check(full1 == (mcnt[1] == 8) && empty1 == (mcnt[1] == 0), {tag, " flags1"}, {full1, empty1}, {mcnt[1] == 8, mcnt[1] == 0});
    check(ovf0 == movf[0] && ovf1 == movf[1], {tag, " ovf"}, {ovf1, ovf0}, {movf[1], movf[0]});
  endtask

  task automatic drain(input string tag);
    while (q0.size() > 0) do_read(0, tag);
    while (q1.size() > 0) do_read(1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    check_state("R1 reset");

    // R6: back-to-back beats, R3 bit pattern variety
    for (int i = 0; i < 3; i++) begin
      beat(14'h0100 + 14'(i), 0);
      beat(14'h3E00 + 14'(i), 0);
    end
    beat(14'h3FFF, 0); beat(14'h0000, 0);
    beat(14'h2AAA, 0); beat(14'h1555, 0);
    idle(0);
    check_state("R5 R6 after burst");
    drain("R3 R4 burst order");
    check_state("R5 drained");

    // R2: gaps do not move the phase
    beat(14'h0011, 0); idle(0); idle(0); beat(14'h2011, 0); idle(0);
    beat(14'h0022, 0); idle(0); beat(14'h2022, 0); idle(0);
    check_state("R2 gaps");
    drain("R2 gapped routing");

    // R9: resync with a beat, and resync alone
    beat(14'h0033, 0); beat(14'h0034, 1); beat(14'h2034, 0);
    beat(14'h0035, 0); idle(1); beat(14'h0036, 0); beat(14'h2036, 0);
    idle(0);
    check_state("R9 resync");
    drain("R9 resync routing");

    // R4: read of empty FIFO
    @(negedge clk); rd0_en = 1'b1; rd1_en = 1'b1;
    @(negedge clk); rd0_en = 1'b0; rd1_en = 1'b0;
    check_state("R4 empty read");
    beat(14'h0044, 0); beat(14'h2044, 0); idle(0);
    drain("R4 after empty read");

    // R7/R8: fill both to full
    for (int i = 0; i < 8; i++) begin
      beat(14'h0400 + 14'(i), 0); beat(14'h2400 + 14'(i), 0);
    end
    idle(0);
    check_state("R5 full");
    do_read(1, "R4 partial"); do_read(1, "R4 partial");
    beat(14'h0555, 0); beat(14'h2555, 0); idle(0);
    check_state("R7 R8 ch0 drop pair");
    do_read(0, "R7 partial");
    beat(14'h0666, 0); beat(14'h2666, 0);
    beat(14'h0777, 0); beat(14'h2777, 0); idle(0);
    check_state("R7 phase kept");
    drain("R7 R8 content");
    check_state("R7 sticky");

    do_reset();
    check_state("R1 second reset");
    beat(14'h0888, 0); beat(14'h2888, 0); idle(0);
    drain("R2 after reset");
    finish_run();
  end
endmodule